// File: doc/BRIEF.md
# Configurable elastic channel buffer

This block sits on one latency-insensitive point-to-point channel and decouples its producer from its consumer. Both sides use a valid/ready handshake with a payload bus. A word moves across an interface in every cycle where valid and ready are both high at the rising clock edge. A producer that raises valid must keep valid high and the payload unchanged until the word is accepted. The consumer may drop or raise ready at any time.

One elaboration-time parameter picks the buffering discipline. The choices are:
- a bare wire with no storage;
- a one-register stage whose ready follows the consumer combinationally;
- a one-register stage with a registered ready and a spare skid slot;
- a one-register stage with a registered ready and no spare slot, which runs at half rate;
- a queue of configurable depth.

The choice sets the channel's latency, how many words it can hold while stalled, and whether back-pressure crosses the block in the same cycle. Changing the discipline never changes the sequence of words that comes out. An active-low asynchronous reset empties every storage slot.

Top module: `elastic_chan_buf`

## Requirements
- R1: In every mode, words leave in the order they were accepted, each exactly once, and a word leaves only after it was accepted.
- R2: Wire mode (KIND=EB_WIRE) has zero latency. out_valid and out_data follow in_valid and in_data in the same cycle, and in_ready equals out_ready in the same cycle. It holds no word while stalled.
- R3: Combinational stage (KIND=EB_COMB) has one cycle of latency and holds one word. in_ready is high when the stage is empty or out_ready is high. With out_ready held high it accepts a word every cycle.
- R4: Skid stage (KIND=EB_SKID) has one cycle of latency. in_ready comes only from registers and is low exactly when the skid slot is occupied. It absorbs 2 words while stalled. With out_ready held high it accepts a word every cycle.
- R5: Half-rate stage (KIND=EB_HALF) has one cycle of latency. in_ready comes only from registers and is high exactly when the stage is empty. It holds one word. A continuous stream takes two cycles per word.
- R6: Queue (KIND=EB_FIFO) has one cycle of latency and holds DEPTH words while stalled. in_ready comes only from registers and is low exactly when it is full. With out_ready held high it accepts a word every cycle.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R8: Asserting rst_n low empties every storage mode at once, without waiting for a clock edge. While empty, out_valid is low and in_ready is high, except in wire mode, where in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Buffer can take a word this cycle |
| in_data | input | W | Offered payload |
| out_valid | output | 1 | Buffer offers a word |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | W | Offered payload, valid when out_valid is high |

## Verification
Checks that run on every cycle cover the following:
- The output payload stays stable while stalled.
- out_valid is low during reset.
- Data never appears without an earlier acceptance.
- Occupancy, counted from handshakes at the ports, never goes beyond the mode's capacity.
- In the registered modes, in_ready falls only after a cycle of stall or intake.

Some properties need stimulus and can only be shown by the bench scenarios. These are exact word ordering across many ready patterns, the throughput of each mode, the exact number of words absorbed under stall, and whether in_ready answers a rising out_ready within the same cycle.

// File: rtl/eb_pkg.sv
package eb_pkg;

  typedef enum logic [2:0] {
    EB_WIRE = 3'd0,
    EB_COMB = 3'd1,
    EB_SKID = 3'd2,
    EB_HALF = 3'd3,
    EB_FIFO = 3'd4
  } eb_kind_e;

  // Words a mode can hold while the consumer is stalled.
  function automatic int eb_capacity(eb_kind_e kind, int depth);
    case (kind)
      EB_WIRE: return 0;
      EB_COMB: return 1;
      EB_SKID: return 2;
      EB_HALF: return 1;
      default: return depth;
    endcase
  endfunction

endpackage

// File: rtl/eb_comb_stage.sv
// One register; ready passes combinationally from the consumer.
module eb_comb_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         load;

  assign in_ready  = ~full_q | out_ready;
  assign load      = in_valid & in_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  // Occupied next cycle if a word arrives, or if the stage is stalled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= in_valid | ~in_ready;
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= in_data;
  end
endmodule

// File: rtl/eb_skid_stage.sv
// Main register plus skid slot; ready is a pure register output.
module eb_skid_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         main_v, skid_v;
  logic [W-1:0] main_d, skid_d;
  logic         push, main_free;

  assign in_ready  = ~skid_v;
  assign push      = in_valid & ~skid_v;
  assign main_free = ~main_v | out_ready;
  assign out_valid = main_v;
  assign out_data  = main_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_v <= 1'b0;
      skid_v <= 1'b0;
    end else if (main_free) begin
      if (skid_v) begin
        main_v <= 1'b1;
        skid_v <= 1'b0;
      end else begin
        main_v <= push;
      end
    end else if (push) begin
      skid_v <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (main_free) begin
      if (skid_v)    main_d <= skid_d;
      else if (push) main_d <= in_data;
    end else if (push) begin
      skid_d <= in_data;
    end
  end
endmodule

// File: rtl/eb_half_stage.sv
// One register, registered ready, no spare slot: alternates fill and drain.
module eb_half_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         push;

  assign in_ready  = ~full_q;
  assign push      = in_valid & ~full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= push | (full_q & ~out_ready);
  end

  always_ff @(posedge clk) begin
    if (push) data_q <= in_data;
  end
endmodule

// File: rtl/eb_queue.sv
// Circular queue; ready derives from the occupancy register only.
module eb_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic          push, pop;

  assign in_ready  = (count_q != FULL);
  assign out_valid = (count_q != '0);
  assign push      = in_valid & in_ready;
  assign pop       = out_valid & out_ready;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end
endmodule

// File: rtl/elastic_chan_buf.sv
module elastic_chan_buf #(
  parameter eb_pkg::eb_kind_e KIND = eb_pkg::EB_SKID,
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  import eb_pkg::*;

  generate
    if (KIND == EB_WIRE) begin : g_wire
      assign out_valid = in_valid;
      assign out_data  = in_data;
      assign in_ready  = out_ready;
    end else if (KIND == EB_COMB) begin : g_comb
      eb_comb_stage #(.W(W)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));
    end else if (KIND == EB_SKID) begin : g_skid
      eb_skid_stage #(.W(W)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));
    end else if (KIND == EB_HALF) begin : g_half
      eb_half_stage #(.W(W)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));
    end else begin : g_fifo
      eb_queue #(.W(W), .DEPTH(DEPTH)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));
    end
  endgenerate
endmodule

// File: rtl/elastic_chan_buf_chk.sv
module elastic_chan_buf_chk #(
  parameter eb_pkg::eb_kind_e KIND = eb_pkg::EB_SKID,
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  import eb_pkg::*;
  localparam int CAP = eb_capacity(KIND, DEPTH);

  // Occupancy reconstructed from port handshakes only.
  int occ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= 0;
    else occ <= occ + int'(in_valid && in_ready) - int'(out_valid && out_ready);
  end

  // R3 R4 R5 R6: never more words inside than the mode's capacity.
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CAP && occ >= 0);

  generate
    if (KIND != EB_WIRE) begin : g_stored
      a_r8_reset_empty: assert property (@(posedge clk)
        !rst_n |-> !out_valid);
      a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
      a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));
    end
    if (KIND == EB_COMB) begin : g_comb
      a_r3_ready_path: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) |-> in_ready);
    end
    if (KIND == EB_SKID || KIND == EB_HALF || KIND == EB_FIFO) begin : g_reg
      a_r4_not_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);
      a_r5_ready_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid && in_ready));
    end
  endgenerate
endmodule

bind elastic_chan_buf elastic_chan_buf_chk #(.KIND(KIND), .DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

// File: tb/tb_elastic_chan_buf.sv
`timescale 1ns/1ps
module tb_elastic_chan_buf;
  import eb_pkg::*;

  localparam int W = 8;
  localparam int QD = 4;
  localparam int N = 5;   // 0 wire, 1 comb, 2 skid, 3 half, 4 queue

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [N-1:0] iv = '0;
  logic [N-1:0] orr = '0;
  logic [W-1:0] id [N];
  wire  [N-1:0] ir, ov;
  wire  [W-1:0] od [N];

  int total = 0;
  int fails = 0;

  elastic_chan_buf #(.KIND(EB_WIRE), .DEPTH(QD), .W(W)) dut_w (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(ir[0]), .in_data(id[0]),
    .out_valid(ov[0]), .out_ready(orr[0]), .out_data(od[0]));
  elastic_chan_buf #(.KIND(EB_COMB), .DEPTH(QD), .W(W)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(ir[1]), .in_data(id[1]),
    .out_valid(ov[1]), .out_ready(orr[1]), .out_data(od[1]));
  elastic_chan_buf #(.KIND(EB_SKID), .DEPTH(QD), .W(W)) dut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[2]), .in_ready(ir[2]), .in_data(id[2]),
    .out_valid(ov[2]), .out_ready(orr[2]), .out_data(od[2]));
  elastic_chan_buf #(.KIND(EB_HALF), .DEPTH(QD), .W(W)) dut_h (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[3]), .in_ready(ir[3]), .in_data(id[3]),
    .out_valid(ov[3]), .out_ready(orr[3]), .out_data(od[3]));
  elastic_chan_buf #(.KIND(EB_FIFO), .DEPTH(QD), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[4]), .in_ready(ir[4]), .in_data(id[4]),
    .out_valid(ov[4]), .out_ready(orr[4]), .out_data(od[4]));

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      iv = '0; orr = '0;
    end
  endtask

  // R8: state during and right after reset.
  task automatic t_reset();
    for (int k = 0; k < N; k++) id[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ov == '0, "R8 out_valid in reset", int'(ov), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ov == '0, "R8 out_valid after reset", int'(ov), 0);
    check(ir == 5'b11110, "R8 in_ready after reset", int'(ir), 30);
  endtask

  // R2: pass-through and same-cycle ready.
  task automatic t_wire_passthru();
    @(posedge clk); #1;
    iv[0] = 1'b1; id[0] = 8'h5A; orr[0] = 1'b0;
    #2;
    check(ov[0] == 1'b1, "R2 valid follows", int'(ov[0]), 1);
    check(od[0] == 8'h5A, "R2 data follows", int'(od[0]), 'h5A);
    check(ir[0] == 1'b0, "R2 ready follows low", int'(ir[0]), 0);
    orr[0] = 1'b1;
    #1;
    check(ir[0] == 1'b1, "R2 ready follows high", int'(ir[0]), 1);
    @(posedge clk); #1;
    iv[0] = 1'b0; orr[0] = 1'b0;
    #1;
    check(ov[0] == 1'b0, "R2 valid drops", int'(ov[0]), 0);
  endtask

  // R1 and throughput: stream n words under a ready pattern.
  task automatic t_stream(int k, int n, int pat, output int cycles);
    int sent = 0, rcvd = 0, cyc = 0;
    logic [W-1:0] base = W'(8'h20 * k + pat);
    while (rcvd < n && cyc < 4000) begin
      @(posedge clk); #1;
      iv[k] = (sent < n);
      id[k] = W'(base + sent);
      case (pat)
        0:       orr[k] = 1'b1;
        1:       orr[k] = cyc[0];
        default: orr[k] = 1'($urandom_range(0, 1));
      endcase
      @(negedge clk);
      if (iv[k] && ir[k]) sent++;
      if (ov[k] && orr[k]) begin
        check(od[k] == W'(base + rcvd), "R1 order", int'(od[k]), int'(W'(base + rcvd)));
        rcvd++;
      end
      cyc++;
    end
    check(rcvd == n, "R1 all delivered", rcvd, n);
    cycles = cyc;
    idle(2);
  endtask

  // R2..R7: stall capacity, latency, held payload, ready response, drain.
  task automatic t_capacity(int k, int cap, bit regd);
    int sent = 0, rcvd = 0;
    logic [W-1:0] base = W'(8'h90 + 8'h08 * k);
    for (int c = 0; c < 10; c++) begin
      @(posedge clk); #1;
      iv[k] = 1'b1; id[k] = W'(base + sent); orr[k] = 1'b0;
      @(negedge clk);
      if (c == 0)
        check(ov[k] == (k == 0), "R3 first-cycle latency", int'(ov[k]), int'(k == 0));
      else if (ov[k])
        check(od[k] == base, "R7 held payload", int'(od[k]), int'(base));
      if (c > 0)
        check(ov[k] == 1'b1, "R7 valid held", int'(ov[k]), 1);
      if (iv[k] && ir[k]) sent++;
    end
    check(sent == cap, "R6 stall capacity", sent, cap);
    check(ir[k] == 1'b0, "R4 ready low when full", int'(ir[k]), 0);
    @(posedge clk); #1;
    iv[k] = 1'b0; orr[k] = 1'b1;
    #1;
    check(ir[k] == !regd, "R5 ready response same cycle", int'(ir[k]), int'(!regd));
    for (int c = 0; c < 20 && rcvd < sent; c++) begin
      if (c > 0) begin @(posedge clk); #1; end
      @(negedge clk);
      if (ov[k] && orr[k]) begin
        check(od[k] == W'(base + rcvd), "R1 drain order", int'(od[k]), int'(W'(base + rcvd)));
        rcvd++;
      end
    end
    check(rcvd == sent, "R1 drain complete", rcvd, sent);
    idle(2);
  endtask

  // R8: reset in the middle of a stall empties the queue at once.
  task automatic t_async_reset();
    for (int c = 0; c < 2; c++) begin
      @(posedge clk); #1;
      iv[4] = 1'b1; id[4] = W'(8'hE0 + c); orr[4] = 1'b0;
    end
    @(posedge clk); #1;
    iv[4] = 1'b0;
    @(negedge clk);
    check(ov[4] == 1'b1, "R8 queue loaded", int'(ov[4]), 1);
    #3 rst_n = 1'b0;
    #1;
    check(ov[4] == 1'b0, "R8 async clear", int'(ov[4]), 0);
    check(ir[4] == 1'b1, "R8 ready after clear", int'(ir[4]), 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    @(negedge clk);
    check(ov[4] == 1'b0, "R8 stays empty", int'(ov[4]), 0);
  endtask

  initial begin
    #(20 * 150000);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    int cyc;
    t_reset();
    t_wire_passthru();
    for (int k = 0; k < N; k++) begin
      t_stream(k, 16, 0, cyc);
      if (k == 0)      check(cyc == 16, "R2 zero latency rate", cyc, 16);
      else if (k == 3) check(cyc == 32, "R5 half rate", cyc, 32);
      else if (k == 1) check(cyc == 17, "R3 full rate", cyc, 17);
      else if (k == 2) check(cyc == 17, "R4 full rate", cyc, 17);
      else             check(cyc == 17, "R6 full rate", cyc, 17);
      t_stream(k, 20, 1, cyc);
      t_stream(k, 40, 2, cyc);
    end
    t_capacity(0, 0, 1'b0);
    t_capacity(1, 1, 1'b0);
    t_capacity(2, 2, 1'b1);
    t_capacity(3, 1, 1'b1);
    t_capacity(4, QD, 1'b1);
    t_async_reset();
    report();
    $finish;
  end
endmodule